// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the execute stage arithmetic/logic unit of a 32-bit integer datapath. Each cycle in which `in_valid` is high it takes a register operand (`op_a`), a second operand that has already passed through a shifter (`op_b`), the shifter's carry-out, a set-flags bit and the current four condition flags (negative, zero, carry, overflow). One cycle later it presents the result, a write enable for the destination register, and the flag values the datapath should hold next.

Ten operations are supported: four arithmetic (add, add with carry, subtract, subtract with carry), four bitwise (and, or, exclusive-or, and-not), a compare that only sets flags, and a move that forwards the second operand. The carry flag after a subtraction means "no borrow occurred", and bitwise and move operations take their carry from the shifter rather than from an adder. Flags pass through unchanged unless the operation asks to set them. Register file, fetch and condition evaluation live outside the block.

The block has one registered stage. Its control is a small classifier that sorts every opcode into one of four classes (arithmetic, bitwise, move, undefined), and the class picks the result source, the write enable and the flag rule.

Top module: `dp_alu`

## Requirements
- R1: A request with `in_valid` high yields `out_valid` high on the next rising edge, with the result, `rd_we` and `flags_out` of that request; a cycle with `in_valid` low yields `out_valid` low and `rd_we` low on the next edge.
- R2: Opcode encoding is 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 and, 5 or, 6 exclusive-or, 7 and-not, 8 compare, 9 move; add-with-carry gives a+b+C and subtract-with-carry gives a−b−(1−C), where C is bit 1 of `flags_in`.
- R3: Bitwise operations return a&b, a|b, a^b and a&~b, with `rd_we` high (e.g. 0xF234012F and 0x000000FF gives 0x0000002F; 0xF2340000 or 0x000012BC gives 0xF23412BC).
- R4: Move returns `op_b` with `rd_we` high, independent of `op_a`.
- R5: Compare computes a−b, drives `rd_we` low, and always updates all four flags, whatever `set_flags` is.
- R6: With `set_flags` low, every operation other than compare leaves `flags_out` equal to `flags_in`.
- R7: Arithmetic operations with flags set give N = result bit 31, Z = (result == 0), C = adder carry-out (for subtraction 1 means no borrow, so 1−1 gives 0 with Z=1, C=1), V = signed overflow; flag bits in `flags_in`/`flags_out` are N bit 3, Z bit 2, C bit 1, V bit 0.
- R8: Bitwise and move operations with flags set give N and Z from the result, C = `shift_carry`, and V unchanged from `flags_in`.
- R9: Opcodes 10 to 15 are undefined: `rd_we` low and `flags_out` equal to `flags_in`.
- R10: During and immediately after reset `out_valid`, `rd_we`, `result` and `flags_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 4 | Operation select (encoding in R2) |
| op_a | input | 32 | Register operand |
| op_b | input | 32 | Shifted second operand |
| set_flags | input | 1 | Request a flag update |
| shift_carry | input | 1 | Carry-out of the shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Operation result |
| rd_we | output | 1 | Destination register write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The two functions that coincide in one cycle are the destination write and the flag update: an arithmetic or bitwise request with `set_flags` high must raise `rd_we` and replace the flags together, while compare updates the flags alone and a cleared `set_flags` writes alone. Directed tasks issue the same operands with `set_flags` high and low and as compare, then judge `rd_we`, `result` and `flags_out` in the following cycle against a reference model in the bench built on wide signed and unsigned integer arithmetic rather than on a carry chain.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_ORR = 4'd5,
        OP_EOR = 4'd6,
        OP_BIC = 4'd7,
        OP_CMP = 4'd8,
        OP_MOV = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ARITH = 2'd1,
        CLS_LOGIC = 2'd2,
        CLS_MOVE  = 2'd3
    } op_cls_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic op_cls_e classify(input logic [3:0] op);
        op_cls_e cls;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: cls = CLS_ARITH;
            OP_AND, OP_ORR, OP_EOR, OP_BIC:         cls = CLS_LOGIC;
            OP_MOV:                                 cls = CLS_MOVE;
            default:                                cls = CLS_NONE;
        endcase
        return cls;
    endfunction

endpackage

// File: rtl/dp_addsub.sv
module dp_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             subtract,
    input  logic             use_carry,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             overflow
);
    localparam int XW = WIDTH + 1;

    logic [WIDTH-1:0] b_eff;
    logic             cin;
    logic [XW-1:0]    total;

    always_comb begin
        b_eff = subtract ? ~b : b;
        cin   = use_carry ? carry_in : subtract;
        total = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
    end

    assign sum       = total[WIDTH-1:0];
    assign carry_out = total[XW-1];
    assign overflow  = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);

endmodule

// File: rtl/dp_logic.sv
module dp_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (sel)
            2'd0: y = a & b;
            2'd1: y = a | b;
            2'd2: y = a ^ b;
            2'd3: y = a & ~b;
        endcase
    end
endmodule

// File: rtl/dp_flags.sv
module dp_flags
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  op_cls_e          cls,
    input  logic             update,
    input  logic [WIDTH-1:0] value,
    input  logic             add_carry,
    input  logic             add_ovf,
    input  logic             shift_carry,
    input  flags_t           cur,
    output flags_t           nxt
);
    always_comb begin
        nxt = cur;
        if (update) begin
            nxt.n = value[WIDTH-1];
            nxt.z = ~|value;
            unique case (cls)
                CLS_ARITH: begin
                    nxt.c = add_carry;
                    nxt.v = add_ovf;
                end
                CLS_LOGIC, CLS_MOVE: begin
                    nxt.c = shift_carry;
                end
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       opcode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             set_flags,
    input  logic             shift_carry,
    input  logic [3:0]       flags_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             rd_we,
    output logic [3:0]       flags_out
);
    op_cls_e          cls;
    logic             is_sub;
    logic             use_c;
    logic             is_cmp;
    logic [WIDTH-1:0] add_y;
    logic             add_c;
    logic             add_v;
    logic [WIDTH-1:0] log_y;
    logic [WIDTH-1:0] res_d;
    logic             we_d;
    logic             upd_d;
    flags_t           cur_f;
    flags_t           nxt_f;

    assign cur_f = flags_t'(flags_in);

    always_comb begin
        cls    = classify(opcode);
        is_cmp = (opcode == OP_CMP);
        is_sub = (opcode == OP_SUB) || (opcode == OP_SBC) || is_cmp;
        use_c  = (opcode == OP_ADC) || (opcode == OP_SBC);
    end

    dp_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a         (op_a),
        .b         (op_b),
        .subtract  (is_sub),
        .use_carry (use_c),
        .carry_in  (cur_f.c),
        .sum       (add_y),
        .carry_out (add_c),
        .overflow  (add_v)
    );

    dp_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .sel (opcode[1:0]),
        .y   (log_y)
    );

    always_comb begin
        unique case (cls)
            CLS_ARITH: res_d = add_y;
            CLS_LOGIC: res_d = log_y;
            CLS_MOVE:  res_d = op_b;
            default:   res_d = '0;
        endcase
        we_d  = (cls != CLS_NONE) && !is_cmp;
        upd_d = (cls != CLS_NONE) && (set_flags || is_cmp);
    end

    dp_flags #(.WIDTH(WIDTH)) u_flags (
        .cls         (cls),
        .update      (upd_d),
        .value       (res_d),
        .add_carry   (add_c),
        .add_ovf     (add_v),
        .shift_carry (shift_carry),
        .cur         (cur_f),
        .nxt         (nxt_f)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            rd_we     <= 1'b0;
            result    <= '0;
            flags_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= res_d;
                rd_we     <= we_d;
                flags_out <= nxt_f;
            end else begin
                rd_we     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       opcode,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             set_flags,
    input logic             shift_carry,
    input logic [3:0]       flags_in,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic             rd_we,
    input logic [3:0]       flags_out
);
    logic is_arith_nc;
    logic is_bitwise;
    assign is_arith_nc = (opcode <= 4'd3);
    assign is_bitwise  = (opcode >= 4'd4) && (opcode <= 4'd7);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !rd_we));

    a_r4_move_forwards_b: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd9) |=> (result == $past(op_b) && rd_we));

    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'd8) |=> (!rd_we && flags_out[2] == (result == '0)));

    a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !set_flags && opcode != 4'd8) |=> (flags_out == $past(flags_in)));

    a_r7_nz_track: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags && is_arith_nc) |=>
        (flags_out[2] == (result == '0) && flags_out[3] == result[WIDTH-1]));

    a_r8_bitwise_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags && is_bitwise) |=>
        (flags_out[1] == $past(shift_carry) && flags_out[0] == $past(flags_in[0])));

    a_r9_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode >= 4'd10) |=> (!rd_we && flags_out == $past(flags_in)));

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .opcode      (opcode),
    .op_a        (op_a),
    .op_b        (op_b),
    .set_flags   (set_flags),
    .shift_carry (shift_carry),
    .flags_in    (flags_in),
    .out_valid   (out_valid),
    .result      (result),
    .rd_we       (rd_we),
    .flags_out   (flags_out)
);

// File: tb/dp_alu_tb.sv
`timescale 1ns/100ps
module dp_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = 4'd0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        set_flags = 1'b0;
    logic        shift_carry = 1'b0;
    logic [3:0]  flags_in = 4'd0;
    logic        out_valid;
    logic [31:0] result;
    logic        rd_we;
    logic [3:0]  flags_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dp_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .set_flags(set_flags), .shift_carry(shift_carry),
        .flags_in(flags_in), .out_valid(out_valid), .result(result),
        .rd_we(rd_we), .flags_out(flags_out)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    // Reference built from the requirement text with wide integer arithmetic.
    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sf, input logic sc, input logic [3:0] fi,
                         output logic [31:0] r, output logic we, output logic [3:0] fo);
        longint unsigned ua = {32'd0, a};
        longint unsigned ub = {32'd0, b};
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint unsigned uf;
        longint sfull;
        longint unsigned k;
        logic c, v;
        fo = fi; r = '0; we = 1'b0; c = 1'b0; v = 1'b0;
        if (op <= 4'd3 || op == 4'd8) begin
            if (op == 4'd0 || op == 4'd1) begin
                k = (op == 4'd1) ? {63'd0, fi[1]} : 64'd0;
                uf = ua + ub + k;
                sfull = sa + sb + longint'(k);
                c = uf[32];
            end else begin
                k = (op == 4'd3) ? {63'd0, !fi[1]} : 64'd0;
                uf = ua - ub - k;
                sfull = sa - sb - longint'(k);
                c = (ua >= ub + k);
            end
            r = uf[31:0];
            v = (sfull > 64'sd2147483647) || (sfull < -64'sd2147483648);
            we = (op != 4'd8);
            if (sf || op == 4'd8) fo = {r[31], r == 32'd0, c, v};
        end else if (op <= 4'd7 || op == 4'd9) begin
            case (op)
                4'd4: r = a & b;
                4'd5: r = a | b;
                4'd6: r = a ^ b;
                4'd7: r = a & ~b;
                default: r = b;
            endcase
            we = 1'b1;
            if (sf) fo = {r[31], r == 32'd0, sc, fi[0]};
        end
    endtask

    task automatic issue(input string req, input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sf, input logic sc, input logic [3:0] fi);
        logic [31:0] er; logic ew; logic [3:0] ef;
        model(op, a, b, sf, sc, fi, er, ew, ef);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; op_a = a; op_b = b;
        set_flags = sf; shift_carry = sc; flags_in = fi;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "out_valid", {31'd0, out_valid}, 32'd1);
        if (ew) chk(req, "result", result, er);
        chk(req, "rd_we", {31'd0, rd_we}, {31'd0, ew});
        chk(req, "flags", {28'd0, flags_out}, {28'd0, ef});
    endtask

    task automatic t_reset();
        chk("R10", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R10", "rd_we", {31'd0, rd_we}, 32'd0);
        chk("R10", "result", result, 32'd0);
        chk("R10", "flags", {28'd0, flags_out}, 32'd0);
    endtask

    task automatic t_arith();
        issue("R2", 4'd0, 32'd7, 32'd9, 1'b1, 1'b0, 4'b0000);
        issue("R2", 4'd1, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0, 4'b0010);
        issue("R2", 4'd3, 32'd5, 32'd3, 1'b1, 1'b0, 4'b0000);
        issue("R2", 4'd3, 32'd5, 32'd3, 1'b1, 1'b0, 4'b0010);
        issue("R7", 4'd2, 32'd1, 32'd1, 1'b1, 1'b0, 4'b0000);
        issue("R7", 4'd0, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b0, 4'b0000);
        issue("R7", 4'd2, 32'h8000_0000, 32'd1, 1'b1, 1'b0, 4'b0000);
        issue("R7", 4'd2, 32'd3, 32'd4, 1'b1, 1'b0, 4'b0011);
        issue("R7", 4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 4'b0000);
    endtask

    task automatic t_bitwise();
        issue("R3", 4'd4, 32'hF234_012F, 32'h0000_00FF, 1'b0, 1'b0, 4'b0000);
        issue("R3", 4'd5, 32'hF234_0000, 32'h0000_12BC, 1'b0, 1'b0, 4'b0000);
        issue("R3", 4'd6, 32'hA5A5_0F0F, 32'hFFFF_0003, 1'b0, 1'b0, 4'b0000);
        issue("R3", 4'd7, 32'h0000_000F, 32'h0000_0005, 1'b0, 1'b0, 4'b0000);
        issue("R8", 4'd5, 32'hF234_0000, 32'h0000_12BC, 1'b1, 1'b1, 4'b0001);
        issue("R8", 4'd4, 32'h0000_FF00, 32'h0000_00FF, 1'b1, 1'b0, 4'b1011);
    endtask

    task automatic t_move();
        issue("R4", 4'd9, 32'h1234_5678, 32'h8000_0008, 1'b1, 1'b1, 4'b0000);
        issue("R4", 4'd9, 32'hDEAD_BEEF, 32'h8000_0008, 1'b0, 1'b0, 4'b0101);
        issue("R8", 4'd9, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0, 4'b1011);
    endtask

    task automatic t_compare();
        issue("R5", 4'd8, 32'd10, 32'd10, 1'b0, 1'b0, 4'b0000);
        issue("R5", 4'd8, 32'd2, 32'd9, 1'b1, 1'b1, 4'b0110);
    endtask

    task automatic t_noflags();
        issue("R6", 4'd2, 32'd1, 32'd1, 1'b0, 1'b0, 4'b1001);
        issue("R6", 4'd0, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b1, 4'b0110);
        issue("R6", 4'd6, 32'd3, 32'd3, 1'b0, 1'b1, 4'b1000);
    endtask

    task automatic t_undefined();
        for (int op = 10; op < 16; op++)
            issue("R9", 4'(op), 32'd4, 32'd5, 1'b1, 1'b1, 4'b1010);
    endtask

    task automatic t_idle();
        issue("R1", 4'd0, 32'd1, 32'd2, 1'b0, 1'b0, 4'b0000);
        @(negedge clk);
        chk("R1", "idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "idle rd_we", {31'd0, rd_we}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arith();
        t_bitwise();
        t_move();
        t_compare();
        t_noflags();
        t_undefined();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule